// File: doc/BRIEF.md
# RTC Seconds Timebase with Drift Correction

This block is the timekeeping core of a real-time clock. A 32768 Hz tick enable drives a two-stage prescaler. The fine stage counts ticks inside one sub-second step of 256 ticks (1/128 s). The coarse stage counts steps inside one second. Each carry out of the coarse stage advances a free-running 32-bit seconds counter. The counter covers the whole unsigned range and wraps to zero.

Two independent corrections trim a slow or fast oscillator. The periodic correction is set by a 19-bit match value M and a 2-bit mode. In one mode the counter gains one extra second on every (M+1)-th second. In the other mode it loses one second at that same interval. The one-shot correction adds or removes a single sub-second step at the next step boundary and then clears its own pending flag. Software can poll that flag to see when the step has been applied.

Software controls the block through two write strobes. One writes the adjust word and the other loads a new seconds value. The adjust word reads back on a status port, and the current sub-second position is also visible.

Top module: `rtc_timebase`

## Requirements
- R1: After a synchronous active-low reset, `seconds`, `subsec` and `adj_status` are all zero.
- R2: Each tick advances `subsec` by one. `seconds` advances by one every 2^(FINE_W+COARSE_W) ticks, which is when `subsec` wraps to zero. With the default parameters this is 32768 ticks.
- R3: `seconds` is a 32-bit unsigned count. It wraps from 0xFFFFFFFF to 0, and to 1 when a second is inserted at that point.
- R4: The adjust word has these fields: match value M in bits [18:0], mode in bits [20:19], periodic-enable in bit 23, step direction in bit 24 (1 = insert, 0 = remove) and step-pending in bit 25. `adj_status` returns these fields in the same positions, and every other bit reads as zero.
- R5: With periodic-enable set and mode 3, every (M+1)-th second advances `seconds` by 2 instead of 1.
- R6: With periodic-enable set and mode 2, every (M+1)-th second leaves `seconds` unchanged.
- R7: Mode 0 or 1, or a clear periodic-enable bit, gives no periodic correction.
- R8: With step-pending set and direction 1, the next fine-stage wrap advances the time by one extra step of 2^FINE_W ticks, carrying into `seconds` if needed.
- R9: With step-pending set and direction 0, the next fine-stage wrap does not advance the coarse stage, so the time loses one step.
- R10: Step-pending stays set until the step is applied and clears on that same tick.
- R11: A load strobe sets `seconds` to `load_val` and clears both the prescaler and the correction period count.
- R12: A write of the adjust word restarts the correction period count.
- R13: While `tick_en` is low, `seconds` and `subsec` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at 32768 Hz |
| adj_wr | input | 1 | Write strobe for the adjust word |
| adj_wdata | input | 32 | Adjust word written by `adj_wr` |
| load_wr | input | 1 | Write strobe for the seconds load value |
| load_val | input | 32 | New seconds value |
| seconds | output | 32 | Current seconds count |
| subsec | output | FINE_W+COARSE_W | Tick position within the current second |
| adj_status | output | 32 | Readback of the adjust word |

## Verification
The embedded assertions check properties that hold on every cycle. Counters hold while there is no tick and no load. The seconds count moves only on a carry, and then by at most 2. A load value lands in the next cycle. The period count never passes M while the correction is active. The pending flag can rise only on a write. Only the bench's scenarios can show that the correction lands on the right second: they sweep every mode, enable and small match value over many periods and compare against an arithmetic expectation. The same applies to the net gain or loss of a one-shot step and to the restart effects of load and adjust writes. Those scenarios use a small prescaler of 16 ticks per second.

// File: rtl/rtc_pkg.sv
// Shared adjust-word layout and helpers for the RTC timebase.
// Assumes a 32-bit control word; field positions are fixed by software.
package rtc_pkg;
    localparam int MATCH_W   = 19;
    localparam int MODE_LSB  = 19;
    localparam int EN_BIT    = 23;
    localparam int DIR_BIT   = 24;
    localparam int PEND_BIT  = 25;

    typedef struct packed {
        logic [MATCH_W-1:0] match;
        logic [1:0]         mode;
        logic               per_en;
        logic               step_dir;
        logic               step_pend;
    } adj_cfg_t;

    // Decode a written word into the stored fields.
    function automatic adj_cfg_t unpack_adj(input logic [31:0] w);
        adj_cfg_t c;
        c.match     = w[MATCH_W-1:0];
        c.mode      = w[MODE_LSB+1:MODE_LSB];
        c.per_en    = w[EN_BIT];
        c.step_dir  = w[DIR_BIT];
        c.step_pend = w[PEND_BIT];
        return c;
    endfunction

    // Rebuild the readback word, unused bits zero.
    function automatic logic [31:0] pack_adj(input adj_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[MATCH_W-1:0]          = c.match;
        w[MODE_LSB+1:MODE_LSB]  = c.mode;
        w[EN_BIT]               = c.per_en;
        w[DIR_BIT]              = c.step_dir;
        w[PEND_BIT]             = c.step_pend;
        return w;
    endfunction
endpackage

// File: rtl/rtc_adj_reg.sv
// Adjust register: holds the correction settings written by software.
// The step-pending flag self-clears when the prescaler reports the step
// applied. A write takes priority over that clear in the same cycle.
module rtc_adj_reg
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [31:0] wdata,
    input  logic        step_done,
    output adj_cfg_t    cfg
);
    // Store settings on write, retire the pending step when applied.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (wr)
            cfg <= unpack_adj(wdata);
        else if (step_done)
            cfg.step_pend <= 1'b0;
    end

    // R10
    pend_rise_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> !$rose(cfg.step_pend));
endmodule

// File: rtl/rtc_prescaler.sv
// Two-stage tick prescaler. The fine stage counts 2^FINE_W ticks per step
// and the coarse stage counts 2^COARSE_W steps per second. A pending
// one-shot step changes the coarse increment to 2 (insert) or 0 (remove)
// at the next fine wrap. Assumes COARSE_W >= 2.
module rtc_prescaler #(
    parameter int FINE_W   = 8,
    parameter int COARSE_W = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic                       load,
    input  logic                       step_pend,
    input  logic                       step_dir,
    output logic                       sec_pulse,
    output logic                       step_done,
    output logic [FINE_W+COARSE_W-1:0] subsec
);
    localparam int SUB_W = FINE_W + COARSE_W;

    logic [FINE_W-1:0]   fine_q;
    logic [COARSE_W-1:0] coarse_q;
    logic                fine_wrap;
    logic [1:0]          coarse_inc;
    logic [COARSE_W:0]   coarse_sum;

    // Work out the coarse increment and carry for this tick.
    always_comb begin
        fine_wrap  = tick_en && (&fine_q);
        coarse_inc = 2'd1;
        if (fine_wrap && step_pend)
            coarse_inc = step_dir ? 2'd2 : 2'd0;
        coarse_sum = {1'b0, coarse_q} + {{(COARSE_W-1){1'b0}}, coarse_inc};
        sec_pulse  = fine_wrap && coarse_sum[COARSE_W] && !load;
        step_done  = fine_wrap && step_pend && !load;
    end

    // Advance both stages on ticks; a load restarts the second.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            fine_q   <= '0;
            coarse_q <= '0;
        end else if (tick_en) begin
            fine_q <= fine_q + 1'b1;
            if (fine_wrap)
                coarse_q <= coarse_sum[COARSE_W-1:0];
        end
    end

    assign subsec = {coarse_q, fine_q};

    // R13
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load) |=> $stable(subsec));
    // R11
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (subsec == {SUB_W{1'b0}}));
endmodule

// File: rtl/rtc_sec_counter.sv
// 32-bit seconds counter with periodic whole-second correction.
// The period count runs while correction is active (enabled, mode 2 or 3).
// When it equals the match value, that second counts 2 (mode 3) or 0
// (mode 2) and the period count restarts. A load or an adjust write
// also restarts it.
module rtc_sec_counter
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sec_pulse,
    input  logic        load,
    input  logic [31:0] load_val,
    input  logic        adj_wr,
    input  adj_cfg_t    cfg,
    output logic [31:0] seconds
);
    logic [MATCH_W-1:0] period_q;
    logic               corr_active;
    logic               corr_hit;
    logic [31:0]        sec_step;

    // Decide whether this second is corrected and by how much.
    always_comb begin
        corr_active = cfg.per_en && cfg.mode[1];
        corr_hit    = corr_active && (period_q == cfg.match);
        sec_step    = 32'd1;
        if (corr_hit)
            sec_step = cfg.mode[0] ? 32'd2 : 32'd0;
    end

    // Update the seconds count on each carry; load overrides.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seconds <= '0;
        else if (load)
            seconds <= load_val;
        else if (sec_pulse)
            seconds <= seconds + sec_step;
    end

    // Track seconds since the last correction.
    always_ff @(posedge clk) begin
        if (!rst_n || load || adj_wr)
            period_q <= '0;
        else if (sec_pulse)
            period_q <= (!corr_active || corr_hit) ? '0 : period_q + 1'b1;
    end

    // R2
    sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_pulse && !load) |=> $stable(seconds));
    // R5
    sec_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !load) |=> ((seconds - $past(seconds)) <= 32'd2));
    // R11
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (seconds == $past(load_val)));
    // R12
    period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        corr_active |-> (period_q <= cfg.match));
endmodule

// File: rtl/rtc_timebase.sv
// RTC timebase top: prescaler, adjust register and seconds counter.
// Assumes tick_en is a single-cycle enable at the tick rate and that
// software does not write the adjust word on the tick that applies a step.
module rtc_timebase
    import rtc_pkg::*;
#(
    parameter int FINE_W   = 8,
    parameter int COARSE_W = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_en,
    input  logic                       adj_wr,
    input  logic [31:0]                adj_wdata,
    input  logic                       load_wr,
    input  logic [31:0]                load_val,
    output logic [31:0]                seconds,
    output logic [FINE_W+COARSE_W-1:0] subsec,
    output logic [31:0]                adj_status
);
    adj_cfg_t cfg;
    logic     sec_pulse;
    logic     step_done;

    rtc_adj_reg u_adj (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (adj_wr),
        .wdata     (adj_wdata),
        .step_done (step_done),
        .cfg       (cfg)
    );

    rtc_prescaler #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .load      (load_wr),
        .step_pend (cfg.step_pend),
        .step_dir  (cfg.step_dir),
        .sec_pulse (sec_pulse),
        .step_done (step_done),
        .subsec    (subsec)
    );

    rtc_sec_counter u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .load      (load_wr),
        .load_val  (load_val),
        .adj_wr    (adj_wr),
        .cfg       (cfg),
        .seconds   (seconds)
    );

    assign adj_status = pack_adj(cfg);
endmodule

// File: tb/rtc_timebase_tb.sv
module rtc_timebase_tb;
    localparam int FW  = 2;
    localparam int CW  = 2;
    localparam int TPS = 1 << (FW + CW);
    localparam int STEP = 1 << FW;
    localparam logic [31:0] MASK = 32'h039F_FFFF;

    logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
    logic adj_wr = 1'b0, load_wr = 1'b0;
    logic [31:0] adj_wdata = '0, load_val = '0;
    logic [31:0] seconds, adj_status;
    logic [FW+CW-1:0] subsec;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rtc_timebase #(.FINE_W(FW), .COARSE_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .adj_wr(adj_wr),
        .adj_wdata(adj_wdata), .load_wr(load_wr), .load_val(load_val),
        .seconds(seconds), .subsec(subsec), .adj_status(adj_status));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_en = 1'b1;
            @(negedge clk) tick_en = 1'b0;
        end
    endtask

    task automatic wr_adj(input logic [31:0] w);
        @(negedge clk) begin adj_wr = 1'b1; adj_wdata = w; end
        @(negedge clk) adj_wr = 1'b0;
    endtask

    task automatic do_load(input logic [31:0] v);
        @(negedge clk) begin load_wr = 1'b1; load_val = v; end
        @(negedge clk) load_wr = 1'b0;
    endtask

    function automatic logic [31:0] cfgw(input int m, input int mode, input int en,
                                          input int dir, input int pend);
        return 32'(m) | (32'(mode) << 19) | (32'(en) << 23) | (32'(dir) << 24) | (32'(pend) << 25);
    endfunction

    // Check time after a load of base L and a net advance of adv ticks.
    task automatic chk_time(input string req, input logic [31:0] L, input int adv);
        chk(req, seconds, L + 32'(adv / TPS));
        chk(req, 32'(subsec), 32'(adv % TPS));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", seconds, 0);
        chk("R1", 32'(subsec), 0);
        chk("R1", adj_status, 0);

        // R2 plain counting and R4 readback with junk bits masked
        wr_adj(32'hFC60_0005);
        chk("R4", adj_status, 32'hFC60_0005 & MASK);
        wr_adj(0);
        do_load(32'd40);
        ticks(7);
        chk_time("R2", 40, 7);
        ticks(TPS * 2);
        chk_time("R2", 40, 7 + TPS * 2);

        // R13 no ticks, nothing moves
        repeat (40) @(negedge clk);
        chk_time("R13", 40, 7 + TPS * 2);

        // R11 load clears prescaler
        do_load(32'd100);
        chk_time("R11", 100, 0);
        ticks(TPS);
        chk_time("R11", 100, TPS);

        // R5 R6 R7 sweep of mode, enable and small match values
        for (int en = 0; en < 2; en++)
            for (int mode = 0; mode < 4; mode++)
                for (int m = 0; m < 4; m++) begin
                    int k = 9;
                    int corr;
                    logic [31:0] w;
                    w = cfgw(m, mode, en, m & 1, 0);
                    wr_adj(w);
                    chk("R4", adj_status, w);
                    do_load(32'd1000);
                    ticks(TPS * k);
                    corr = 0;
                    if (en == 1 && mode == 3) corr = k / (m + 1);
                    if (en == 1 && mode == 2) corr = -(k / (m + 1));
                    if (en == 1 && mode == 3)      chk("R5", seconds, 32'(1000 + k + corr));
                    else if (en == 1 && mode == 2) chk("R6", seconds, 32'(1000 + k + corr));
                    else                           chk("R7", seconds, 32'(1000 + k));
                end

        // R5 large match: no correction within the window
        wr_adj(cfgw(19'h7FFFF, 3, 1, 0, 0));
        do_load(32'd0);
        ticks(TPS * 9);
        chk("R5", seconds, 9);

        // R3 wrap with insertion, then swallow at every second
        wr_adj(cfgw(0, 3, 1, 0, 0));
        do_load(32'hFFFF_FFFF);
        ticks(TPS);
        chk("R3", seconds, 32'd1);
        wr_adj(cfgw(0, 2, 1, 0, 0));
        do_load(32'd5);
        ticks(TPS * 2);
        chk("R6", seconds, 32'd5);

        // R11 load restarts the period count
        wr_adj(cfgw(2, 3, 1, 0, 0));
        do_load(0);
        ticks(TPS * 2);
        do_load(0);
        ticks(TPS * 2);
        chk("R11", seconds, 2);

        // R12 adjust write restarts the period count
        do_load(0);
        ticks(TPS * 2);
        wr_adj(cfgw(2, 3, 1, 0, 0));
        ticks(TPS * 2);
        chk("R12", seconds, 4);

        // R8 R10 one-shot insert from the start of a second
        wr_adj(0);
        do_load(0);
        wr_adj(cfgw(0, 0, 0, 1, 1));
        ticks(STEP - 1);
        chk("R10", adj_status, cfgw(0, 0, 0, 1, 1));
        ticks(1);
        chk("R10", adj_status, cfgw(0, 0, 0, 1, 0));
        ticks(20 - STEP);
        chk_time("R8", 0, 20 + STEP);

        // R8 insert near the end of a second carries into seconds
        do_load(10);
        ticks(TPS - STEP);
        wr_adj(cfgw(0, 0, 0, 1, 1));
        ticks(STEP);
        chk_time("R8", 10, TPS + STEP);

        // R9 R10 one-shot removal
        do_load(50);
        wr_adj(cfgw(0, 0, 0, 0, 1));
        ticks(STEP);
        chk("R10", adj_status, 0);
        ticks(20 - STEP);
        chk_time("R9", 50, 20 - STEP);

        // R9 removal at the last step of a second delays the carry
        do_load(70);
        ticks(TPS - STEP);
        wr_adj(cfgw(0, 0, 0, 0, 1));
        ticks(STEP);
        chk_time("R9", 70, TPS - STEP);
        ticks(STEP);
        chk_time("R9", 70, TPS);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule